// File: doc/BRIEF.md
# Transceiver Operating-Mode Controller

This block sequences the operating mode of a four-channel bus transceiver between three states: a low-power sleep state, an intermediate standby state reached only through a remote wake-up, and the normal communicating state. It watches an enable pin and one sampled bus level per channel. Its outputs are the current mode, a per-channel flag naming the channels that woke the device, and a per-channel drive control for the receive-data pins.

The enable pin is debounced by two separate counters. One qualifies a high level before normal mode is entered. The other qualifies a low level before normal mode is left for sleep. A remote wake-up is a dominant level held at least a parameterised number of cycles, followed by a return to recessive. Wake-ups are detected in sleep, and also in normal mode while the enable pin is low and the exit filter is counting. A wake-up seen in that exit window sends the controller to standby instead of sleep. All filter lengths are parameters counted in clock cycles. The synchronous reset stands for power-on reset.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: While reset is high and on the first cycles after it is released, `mode` is 0 (sleep), `wake_flag` is all zero and every receive-data control is 0 (high-impedance).
- R2: From sleep or standby, `mode` becomes 2 (normal) on the clock edge where `en` is sampled high for the (EN_ON_CYC+1)-th consecutive time. A shorter high period leaves the mode unchanged.
- R3: In standby, the first clock edge that samples `en` high clears `wake_flag` and sets every receive-data control to high-impedance. The mode stays standby until R2 completes.
- R4: From normal, `mode` becomes 0 (sleep) on the edge where `en` is sampled low for the (EN_OFF_CYC+1)-th consecutive time. This happens even while every bus input is held dominant.
- R5: A channel wakes when its `bus_dom` bit (1 = dominant) has been sampled high for at least WAKE_CYC consecutive edges and is then sampled low. On that edge the mode becomes 1 (standby).
- R6: Wake-up detection is active only in sleep, and in normal while `en` is low. Dominant pulses in standby, or in normal with `en` high, change neither the mode nor `wake_flag`.
- R7: A wake-up completed while the exit filter of R4 is running moves the controller from normal to standby, not to sleep.
- R8: Each channel detects wake-ups on its own. `wake_flag[i]` is set exactly for the channels that completed a wake-up on the edge that entered standby.
- R9: Receive-data control for channel i is `rxd_ctl[2i+1:2i]`, with 0 = high-impedance, 1 = forced low and 2 = pass-through. In standby, a channel with its wake flag set reads 1 and every other channel reads 0. In sleep, all channels read 0.
- R10: A dominant pulse shorter than WAKE_CYC samples raises no flag, and its count does not carry over into a later pulse.
- R11: A single low sample of `en` during the entry filter restarts the count, so a full EN_ON_CYC+1 fresh high samples are needed.
- R12: In normal mode every receive-data control is 2 (pass-through) and `wake_flag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on reset) |
| en | input | 1 | Mode enable pin, sampled |
| bus_dom | input | NCH | Per-channel bus level, 1 = dominant |
| mode | output | 2 | 0 sleep, 1 standby, 2 normal |
| wake_flag | output | NCH | Channels that caused the last wake-up |
| rxd_ctl | output | 2*NCH | Per-channel receive-data drive code |

## Verification
The hardest state to reach is a wake-up that completes inside the normal-to-sleep exit window. The dominant pulse has to begin after `en` falls, and its recessive edge has to land before the exit filter expires. The bench does this by lowering `en` and raising one bus bit in the same cycle. It then releases the bus after exactly WAKE_CYC samples, which is one sample short of the exit filter length. Pulse-length and enable-length sweeps reach the exact threshold cycles from both sides.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_SLEEP   = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_NORMAL  = 2'd2
    } op_mode_e;

    typedef enum logic [1:0] {
        RXD_HIZ  = 2'd0,
        RXD_LOW  = 2'd1,
        RXD_PASS = 2'd2
    } rxd_drv_e;

    // Drive code for one receive-data pin given mode and its wake flag
    function automatic rxd_drv_e rxd_code(op_mode_e m, logic woke);
        rxd_drv_e r;
        case (m)
            MODE_NORMAL:  r = RXD_PASS;
            MODE_STANDBY: r = woke ? RXD_LOW : RXD_HIZ;
            default:      r = RXD_HIZ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/en_filter.sv
module en_filter #(
    parameter int ON_CYC  = 4,
    parameter int OFF_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic on_done,
    output logic off_done
);
    localparam int HW = $clog2(ON_CYC + 1);
    localparam int LW = $clog2(OFF_CYC + 1);
    localparam logic [HW-1:0] HI_MAX = HW'(ON_CYC);
    localparam logic [LW-1:0] LO_MAX = LW'(OFF_CYC);

    logic [HW-1:0] hi_cnt;
    logic [LW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            if (!en)                  hi_cnt <= '0;
            else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
            if (en)                   lo_cnt <= '0;
            else if (lo_cnt != LO_MAX) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    // Level already held for the full count and still present this cycle
    assign on_done  = en  && (hi_cnt == HI_MAX);
    assign off_done = !en && (lo_cnt == LO_MAX);

endmodule

// File: rtl/wake_det.sv
module wake_det #(
    parameter int WAKE_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic dom,
    output logic hit
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] CMAX = CW'(WAKE_CYC);

    logic [CW-1:0] dom_cnt;

    always_ff @(posedge clk) begin
        if (rst || !arm || !dom) dom_cnt <= '0;
        else if (dom_cnt != CMAX) dom_cnt <= dom_cnt + 1'b1;
    end

    // Recessive edge after a long enough dominant phase
    assign hit = arm && !dom && (dom_cnt == CMAX);

    assert_hit_after_dominant_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(dom));

    assert_disarmed_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !hit);

endmodule

// File: rtl/mode_fsm.sv
module mode_fsm
    import xcvr_mode_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic           on_done,
    input  logic           off_done,
    input  logic [NCH-1:0] wake_hit,
    output op_mode_e       mode_q,
    output logic [NCH-1:0] wmask_q
);
    logic wake_any;
    assign wake_any = |wake_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_SLEEP;
            wmask_q <= '0;
        end else begin
            case (mode_q)
                MODE_SLEEP: begin
                    if (on_done) begin
                        mode_q <= MODE_NORMAL;
                    end else if (wake_any) begin
                        mode_q  <= MODE_STANDBY;
                        wmask_q <= wake_hit;
                    end
                end
                MODE_STANDBY: begin
                    if (en) wmask_q <= '0;
                    if (on_done) mode_q <= MODE_NORMAL;
                end
                MODE_NORMAL: begin
                    if (wake_any) begin
                        mode_q  <= MODE_STANDBY;
                        wmask_q <= wake_hit;
                    end else if (off_done) begin
                        mode_q <= MODE_SLEEP;
                    end
                end
                default: mode_q <= MODE_SLEEP;
            endcase
        end
    end

    assert_entry_needs_filter_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_NORMAL && !on_done) |=> (mode_q != MODE_NORMAL));

    assert_exit_needs_filter_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_NORMAL && !off_done) |=> (mode_q != MODE_SLEEP));

    assert_standby_release_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STANDBY && en) |=> (wmask_q == '0));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
    import xcvr_mode_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int EN_ON_CYC  = 4,
    parameter int EN_OFF_CYC = 6,
    parameter int WAKE_CYC   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [NCH-1:0]   bus_dom,
    output logic [1:0]       mode,
    output logic [NCH-1:0]   wake_flag,
    output logic [2*NCH-1:0] rxd_ctl
);
    logic           on_done, off_done;
    logic [NCH-1:0] wake_hit;
    logic [NCH-1:0] wmask;
    op_mode_e       cur_mode;
    logic           det_arm;

    en_filter #(.ON_CYC(EN_ON_CYC), .OFF_CYC(EN_OFF_CYC)) u_filt (
        .clk(clk), .rst(rst), .en(en), .on_done(on_done), .off_done(off_done)
    );

    // Detection window: sleep, or normal while the exit filter runs
    assign det_arm = (cur_mode == MODE_SLEEP) || (cur_mode == MODE_NORMAL && !en);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        wake_det #(.WAKE_CYC(WAKE_CYC)) u_wake (
            .clk(clk), .rst(rst), .arm(det_arm), .dom(bus_dom[i]), .hit(wake_hit[i])
        );
        assign rxd_ctl[2*i +: 2] = rxd_code(cur_mode, wmask[i]);
    end

    mode_fsm #(.NCH(NCH)) u_fsm (
        .clk(clk), .rst(rst), .en(en), .on_done(on_done), .off_done(off_done),
        .wake_hit(wake_hit), .mode_q(cur_mode), .wmask_q(wmask)
    );

    assign mode      = cur_mode;
    assign wake_flag = wmask;

    assert_flags_only_standby_R12: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != MODE_STANDBY) |-> (wake_flag == '0));

endmodule

// File: tb/tb_xcvr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_xcvr_mode_ctrl;
    localparam int NCH = 4, ON = 4, OFF = 6, WK = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [NCH-1:0] bus_dom = '0;
    logic [1:0] mode;
    logic [NCH-1:0] wake_flag;
    logic [2*NCH-1:0] rxd_ctl;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    xcvr_mode_ctrl #(.NCH(NCH), .EN_ON_CYC(ON), .EN_OFF_CYC(OFF), .WAKE_CYC(WK)) dut (
        .clk(clk), .rst(rst), .en(en), .bus_dom(bus_dom),
        .mode(mode), .wake_flag(wake_flag), .rxd_ctl(rxd_ctl)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; en = 1'b0; bus_dom = '0;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    function automatic logic [2*NCH-1:0] standby_rxd(logic [NCH-1:0] m);
        logic [2*NCH-1:0] r = '0;
        for (int i = 0; i < NCH; i++) if (m[i]) r[2*i +: 2] = 2'd1;
        return r;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog got=hang exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 mode", mode, 0);
        chk("R1 flags", wake_flag, 0);
        chk("R1 rxd", rxd_ctl, 0);
        tick();
        chk("R1 mode after release", mode, 0);

        // R2 entry filter sweep
        for (int d = 1; d <= 8; d++) begin
            do_reset();
            en = 1'b1;
            repeat (d) tick();
            en = 1'b0;
            chk("R2 entry", mode, (d >= ON + 1) ? 2 : 0);
        end

        // R11 glitch restarts entry filter
        do_reset();
        en = 1'b1; repeat (ON - 1) tick();
        en = 1'b0; tick();
        en = 1'b1; repeat (ON - 1) tick();
        chk("R11 glitch holds sleep", mode, 0);
        repeat (2) tick();
        chk("R11 full count enters", mode, 2);
        chk("R12 rxd pass", rxd_ctl, 8'b10101010);
        chk("R12 flags zero", wake_flag, 0);

        // R4 exit filter sweep, half with stuck dominant bus
        for (int d = 1; d <= 9; d++) begin
            do_reset();
            en = 1'b1; repeat (ON + 1) tick();
            bus_dom = (d % 2 == 0) ? 4'hF : 4'h0;
            en = 1'b0;
            repeat (d) tick();
            chk("R4 exit", mode, (d >= OFF + 1) ? 0 : 2);
            en = 1'b1;
        end

        // R5 R8 R9 R10 wake pulse sweep per channel
        for (int ch = 0; ch < NCH; ch++) begin
            for (int p = 1; p <= 7; p++) begin
                logic [NCH-1:0] m;
                do_reset();
                bus_dom[ch] = 1'b1; repeat (p) tick();
                bus_dom = '0; tick();
                m = (p >= WK) ? NCH'(1 << ch) : '0;
                chk("R5 wake mode", mode, (p >= WK) ? 1 : 0);
                chk("R8 wake flag", wake_flag, m);
                chk("R9 standby rxd", rxd_ctl, standby_rxd(m));
            end
        end

        // R10 short pulses do not accumulate
        do_reset();
        bus_dom = 4'b0010; repeat (WK - 2) tick();
        bus_dom = '0; tick();
        bus_dom = 4'b0010; repeat (WK - 2) tick();
        bus_dom = '0; tick();
        chk("R10 no accumulate", mode, 0);
        chk("R10 no flag", wake_flag, 0);

        // R8 two channels together
        do_reset();
        bus_dom = 4'b0101; repeat (WK) tick();
        bus_dom = '0; tick();
        chk("R8 multi flag", wake_flag, 4'b0101);
        chk("R9 multi rxd", rxd_ctl, 8'b00010001);

        // R6 pulses ignored in standby
        bus_dom = 4'b0010; repeat (WK + 1) tick();
        bus_dom = '0; tick();
        chk("R6 standby ignores mode", mode, 1);
        chk("R6 standby ignores flag", wake_flag, 4'b0101);

        // R3 release on first enable sample
        en = 1'b1; tick();
        chk("R3 still standby", mode, 1);
        chk("R3 rxd hiz", rxd_ctl, 0);
        chk("R3 flags cleared", wake_flag, 0);
        en = 1'b0; tick();
        chk("R3 stays hiz", rxd_ctl, 0);
        en = 1'b1; repeat (ON + 1) tick();
        chk("R2 standby to normal", mode, 2);

        // R6 pulses ignored in normal with enable high
        bus_dom = 4'b0100; repeat (WK + 1) tick();
        bus_dom = '0; tick();
        chk("R6 normal ignores", mode, 2);
        chk("R6 normal no flag", wake_flag, 0);

        // R7 wake inside exit window
        en = 1'b0; bus_dom = 4'b1000;
        repeat (WK) tick();
        chk("R7 window open", mode, 2);
        bus_dom = '0; tick();
        chk("R7 diverted to standby", mode, 1);
        chk("R7 flag", wake_flag, 4'b1000);
        chk("R9 rxd ch3 low", rxd_ctl, 8'b01000000);
        repeat (OFF + 3) tick();
        chk("R7 standby holds", mode, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule